// File: doc/BRIEF.md
# Receive Descriptor Ring Filler

This engine takes one received frame at a time from a byte stream and scatters it into the free buffers of a circular receive descriptor ring held in memory. Each descriptor is two 32-bit words: a status/length word and a buffer address. The engine reads a descriptor, checks that software has marked it empty, and copies bytes into its buffer up to a configured per-buffer limit. It then writes back the length and updated status bits and moves to the next descriptor. An optional zero-filled control block can be placed ahead of the frame data. Four zero bytes are always added after the data in place of a checksum tail, and they count toward the frame size.

The frame is first captured into an internal store. If the ring runs out of empty descriptors part-way through, the engine halts with the unwritten remainder held inside. After a restart pulse it finishes that same frame without the sender replaying it. On the descriptor that completes a frame it reports oversize and undersize conditions. It raises per-buffer or per-frame events for descriptors that request an interrupt.

Top module: `rxr_ring_filler`

## Requirements
- R1: A frame is discarded, with one `ev_drop` pulse and no memory write, when receive is disabled (`cfg_rx_en`=0), when a graceful stop is requested (`cfg_gstop`=1), or when an earlier frame is still held because the ring halted.
- R2: With `cfg_short_drop`=1, a frame of fewer than 60 bytes is discarded with one `ev_drop` pulse and no memory write; a 60-byte frame is accepted.
- R3: With `cfg_cb_en`=1, (8 + `cfg_cb_pad`) zero bytes are written at the start of the first buffer, ahead of the frame data.
- R4: Four zero bytes follow the last data byte. The buffers receive exactly control block + frame + 4 bytes, one memory write per byte, plus one write-back per used descriptor.
- R5: Each empty descriptor receives min(remaining bytes, `cfg_max_buf`) bytes. Its length field is set to that count and its empty flag (bit 15 of the status field) is cleared. The first descriptor of a frame gets the first flag (bit 11), and later descriptors do not, including those filled after a restart.
- R6: On the descriptor that completes a frame, status bits 10..0 are cleared and the last flag (bit 10) is set. Bit 5 is set if frame length + 4 >= `cfg_max_frame`. Bit 3 is set if frame length + 4 < 64. Bits 15..11 other than empty keep their values.
- R7: A descriptor with the interrupt flag (bit 12) raises `ev_frame` if it completes the frame and `ev_buf` otherwise. A descriptor without the flag raises neither.
- R8: `ring_ptr` resets to 0 and loads `cfg_ptr_value` (low 3 bits cleared) on `cfg_ptr_load`. After each descriptor the walk goes to `cfg_ring_base` if the wrap flag (bit 13) was set, otherwise to the next 8-byte slot. When a walk ends, `ring_ptr` holds the address after the last descriptor visited.
- R9: If bytes remain when the walk meets a non-empty descriptor, or returns to its starting address, `ring_halt` rises and stays high. A non-empty descriptor is passed over unchanged. A `ring_restart` pulse clears the halt and continues the same frame from `ring_ptr`.
- R10: Descriptor word 0 carries status in bits 31..16 and length in bits 15..0. Word 1, at offset 4, is the byte address of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fin_valid | input | 1 | Frame byte valid |
| fin_data | input | 8 | Frame byte |
| fin_last | input | 1 | Final byte of the frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| cfg_ring_base | input | AW | Address of the first descriptor of the ring |
| cfg_ptr_load | input | 1 | Load the current descriptor pointer |
| cfg_ptr_value | input | AW | Value for the pointer load |
| cfg_max_buf | input | 16 | Bytes allowed per buffer |
| cfg_max_frame | input | 16 | Oversize threshold |
| cfg_cb_en | input | 1 | Prepend a zeroed control block |
| cfg_cb_pad | input | 5 | Extra control block bytes beyond 8 |
| cfg_short_drop | input | 1 | Discard frames under 60 bytes |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_gstop | input | 1 | Graceful receive stop |
| ring_restart | input | 1 | Resume a halted frame |
| ev_buf | output | 1 | Pulse: interrupting non-final buffer done |
| ev_frame | output | 1 | Pulse: interrupting final buffer done |
| ev_drop | output | 1 | Pulse: frame discarded |
| ring_halt | output | 1 | Ring halted with a frame still held |
| busy | output | 1 | Walk in progress |
| ring_ptr | output | AW | Current descriptor pointer |

## Verification
A wrong stream position or chunk count appears as misplaced or missing zero bytes, or as a wrong length field in the very descriptor being written. A stale first-in-frame marker shows up only after a halt and restart, on the first descriptor filled on resume. A bad next-address computation corrupts `ring_ptr` at the end of the same walk, and it sends the following frame to the wrong slot. A held-frame flag that never clears makes every later frame produce `ev_drop`.

// File: rtl/rxr_pkg.sv
// Shared descriptor status bit positions and state encodings for the
// receive ring filler. Assumes a 16-bit status field in word 0 bits 31..16.
package rxr_pkg;
    localparam int FL_EMPTY = 15;
    localparam int FL_WRAP  = 13;
    localparam int FL_INT   = 12;
    localparam int FL_FIRST = 11;
    localparam int FL_LAST  = 10;
    localparam int FL_LONG  = 5;
    localparam int FL_SHORT = 3;
    localparam int FL_CLR_W = 11;   // low status bits wiped on the final descriptor

    localparam int DESC_BYTES = 8;
    localparam logic [15:0] SHORT_DROP_LEN = 16'd60;
    localparam logic [15:0] SHORT_FLAG_LEN = 16'd64;
    localparam logic [15:0] TAIL_BYTES     = 16'd4;
    localparam logic [15:0] CB_BASE_BYTES  = 16'd8;

    typedef enum logic [1:0] {C_WAIT, C_CAP, C_DROP} cap_st_t;

    typedef enum logic [2:0] {
        W_IDLE, W_RD0, W_RD1, W_CHK, W_FILL, W_WB, W_NEXT, W_HALT
    } walk_st_t;
endpackage

// File: rtl/rxr_frame_store.sv
// Captures one frame from the byte stream into a local buffer and hands it
// to the ring walker. Refuses frames while one is held or when receive is
// off/stopped, and drops short frames when asked.
// Assumes frames are no longer than MAX_LEN bytes.
module rxr_frame_store
    import rxr_pkg::*;
#(
    parameter int MAX_LEN = 256,
    localparam int IW = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          rx_en,
    input  logic          gstop,
    input  logic          short_drop,
    input  logic          release_i,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic          frame_go,
    output logic [15:0]   frame_len,
    output logic          ev_drop
);
    cap_st_t     st;
    logic        held;
    logic [15:0] cnt;
    logic [7:0]  buf_mem [MAX_LEN];
    logic        refuse;
    logic        wr_en;
    logic [IW-1:0] wr_idx;
    logic [15:0] fin_len;

    // Refusal decided on the first byte of a frame.
    assign refuse = held || !rx_en || gstop;
    // Length the frame will have if this byte is its last.
    assign fin_len = (st == C_WAIT) ? 16'd1 : cnt + 16'd1;

    // Byte write into the local buffer.
    assign wr_en  = in_valid && ((st == C_WAIT && !refuse) || st == C_CAP) && (cnt < 16'(MAX_LEN));
    assign wr_idx = (st == C_WAIT) ? '0 : IW'(cnt);

    // Buffer storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) buf_mem[wr_idx] <= in_data;
    end

    // Buffer read port used by the walker.
    assign rd_byte = buf_mem[rd_idx];

    // Capture state machine with hand-off and release of the held frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= C_WAIT;
            held      <= 1'b0;
            cnt       <= '0;
            frame_go  <= 1'b0;
            frame_len <= '0;
            ev_drop   <= 1'b0;
        end else begin
            frame_go <= 1'b0;
            ev_drop  <= 1'b0;
            if (release_i) held <= 1'b0;
            case (st)
                C_WAIT: if (in_valid) begin
                    if (refuse) begin
                        ev_drop <= 1'b1;
                        if (!in_last) st <= C_DROP;
                    end else begin
                        cnt <= 16'd1;
                        if (!in_last) st <= C_CAP;
                    end
                end
                C_CAP: if (in_valid) begin
                    cnt <= fin_len;
                    if (in_last) st <= C_WAIT;
                end
                C_DROP: if (in_valid && in_last) st <= C_WAIT;
                default: st <= C_WAIT;
            endcase
            // Finalize an accepted frame on its last byte.
            if (in_valid && in_last && ((st == C_WAIT && !refuse) || st == C_CAP)) begin
                if (short_drop && fin_len < SHORT_DROP_LEN) begin
                    ev_drop <= 1'b1;
                end else begin
                    held      <= 1'b1;
                    frame_go  <= 1'b1;
                    frame_len <= fin_len;
                end
            end
        end
    end

    AST_HELD_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !release_i && st == C_WAIT && in_valid) |=> (st != C_CAP && !frame_go)); // R1
    AST_SHORT_NOT_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_go |-> !($past(short_drop) && frame_len < SHORT_DROP_LEN)); // R2
endmodule

// File: rtl/rxr_stream_sel.sv
// Maps a position in the outgoing byte stream (control block, frame data,
// zero tail) to the byte value to write and the store index to read.
module rxr_stream_sel #(
    parameter int IW = 8
) (
    input  logic [15:0]   pos,
    input  logic [15:0]   cb_len,
    input  logic [15:0]   flen,
    input  logic [7:0]    rd_byte,
    output logic [IW-1:0] rd_idx,
    output logic [7:0]    byte_o
);
    logic in_data;

    // Frame data occupies [cb_len, cb_len+flen); everything else is zero.
    always_comb begin
        in_data = (pos >= cb_len) && (pos < cb_len + flen);
        rd_idx  = IW'(pos - cb_len);
        byte_o  = in_data ? rd_byte : 8'h00;
    end
endmodule

// File: rtl/rxr_ring_walker.sv
// Walks the descriptor ring for a held frame: reads each descriptor,
// fills empty buffers one byte per cycle, writes status/length back,
// advances with wrap, and halts with resumable state when it runs dry.
// Assumes a memory port with one-cycle read latency and no back-pressure.
module rxr_ring_walker
    import rxr_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [15:0]   frame_len,
    output logic          release_o,
    output logic [IW-1:0] rd_idx,
    input  logic [7:0]    rd_byte,
    input  logic          cb_en,
    input  logic [4:0]    cb_pad,
    input  logic [15:0]   max_buf,
    input  logic [15:0]   max_frm,
    input  logic [AW-1:0] ring_base,
    input  logic          ptr_load,
    input  logic [AW-1:0] ptr_value,
    input  logic          restart,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          ev_buf,
    output logic          ev_frame,
    output logic          ring_halt,
    output logic          busy,
    output logic [AW-1:0] ring_ptr
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(DESC_BYTES - 1);
    localparam logic [AW-1:0] STEP       = AW'(DESC_BYTES);

    walk_st_t    st;
    logic [AW-1:0] ptr, start_addr, bufp, wa, nxt;
    logic [15:0] flags, nf;
    logic [15:0] flen, fsize, total, pos, cnt, chunk, cb_len, rem;
    logic        first_pend, last_bd, stop_ne;
    logic [7:0]  fill_byte;

    assign rem      = total - pos;
    assign wa       = bufp + AW'(cnt);
    assign nxt      = flags[FL_WRAP] ? (ring_base & ALIGN_MASK) : ptr + STEP;
    assign ring_ptr = ptr;
    assign busy     = (st != W_IDLE) && (st != W_HALT);

    rxr_stream_sel #(.IW(IW)) i_sel (
        .pos     (pos),
        .cb_len  (cb_len),
        .flen    (flen),
        .rd_byte (rd_byte),
        .rd_idx  (rd_idx),
        .byte_o  (fill_byte)
    );

    // Status word to write back for the current descriptor.
    always_comb begin
        nf = flags;
        if (chunk != 16'd0) begin
            nf[FL_EMPTY] = 1'b0;
            if (first_pend) nf[FL_FIRST] = 1'b1;
        end
        if (last_bd) begin
            nf[FL_CLR_W-1:0] = '0;
            nf[FL_LAST]  = 1'b1;
            nf[FL_LONG]  = (fsize >= max_frm);
            nf[FL_SHORT] = (fsize < SHORT_FLAG_LEN);
        end
    end

    // Memory port drive per walk state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_be    = 4'h0;
        mem_wdata = '0;
        case (st)
            W_RD0: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
            end
            W_RD1: begin
                mem_req  = 1'b1;
                mem_addr = ptr + AW'(4);
            end
            W_FILL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {wa[AW-1:2], 2'b00};
                mem_be    = 4'b0001 << wa[1:0];
                mem_wdata = {4{fill_byte}};
            end
            W_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr;
                mem_be    = 4'hF;
                mem_wdata = {nf, chunk};
            end
            default: ;
        endcase
    end

    // Walk sequencing, pointer update, halt and events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= W_IDLE;
            ptr        <= '0;
            start_addr <= '0;
            bufp       <= '0;
            flags      <= '0;
            flen       <= '0;
            fsize      <= '0;
            total      <= '0;
            pos        <= '0;
            cnt        <= '0;
            chunk      <= '0;
            cb_len     <= '0;
            first_pend <= 1'b0;
            last_bd    <= 1'b0;
            stop_ne    <= 1'b0;
            ring_halt  <= 1'b0;
            release_o  <= 1'b0;
            ev_buf     <= 1'b0;
            ev_frame   <= 1'b0;
        end else begin
            release_o <= 1'b0;
            ev_buf    <= 1'b0;
            ev_frame  <= 1'b0;
            case (st)
                W_IDLE: begin
                    if (ptr_load) ptr <= ptr_value & ALIGN_MASK;
                    if (go) begin
                        flen       <= frame_len;
                        fsize      <= frame_len + TAIL_BYTES;
                        cb_len     <= cb_en ? CB_BASE_BYTES + {11'b0, cb_pad} : 16'd0;
                        total      <= (cb_en ? CB_BASE_BYTES + {11'b0, cb_pad} : 16'd0)
                                      + frame_len + TAIL_BYTES;
                        pos        <= '0;
                        first_pend <= 1'b1;
                        start_addr <= ptr;
                        st         <= W_RD0;
                    end
                end
                W_RD0: st <= W_RD1;
                W_RD1: begin
                    flags <= mem_rdata[31:16];
                    st    <= W_CHK;
                end
                W_CHK: begin
                    bufp <= mem_rdata[AW-1:0];
                    cnt  <= '0;
                    if (!flags[FL_EMPTY]) begin
                        stop_ne <= 1'b1;
                        st      <= W_NEXT;
                    end else begin
                        stop_ne <= 1'b0;
                        chunk   <= (rem <= max_buf) ? rem : max_buf;
                        last_bd <= (rem <= max_buf);
                        st      <= (max_buf == 16'd0) ? W_WB : W_FILL;
                    end
                end
                W_FILL: begin
                    pos <= pos + 16'd1;
                    cnt <= cnt + 16'd1;
                    if (cnt + 16'd1 == chunk) st <= W_WB;
                end
                W_WB: begin
                    if (flags[FL_INT]) begin
                        if (last_bd) ev_frame <= 1'b1;
                        else         ev_buf   <= 1'b1;
                    end
                    if (chunk != 16'd0) first_pend <= 1'b0;
                    st <= W_NEXT;
                end
                W_NEXT: begin
                    ptr <= nxt;
                    if (rem == 16'd0) begin
                        release_o <= 1'b1;
                        st        <= W_IDLE;
                    end else if (stop_ne || nxt == start_addr) begin
                        ring_halt <= 1'b1;
                        st        <= W_HALT;
                    end else begin
                        st <= W_RD0;
                    end
                end
                W_HALT: if (restart) begin
                    ring_halt  <= 1'b0;
                    start_addr <= ptr;
                    st         <= W_RD0;
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_halt && !restart) |=> ring_halt); // R9
    AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == 4'hF) |-> (mem_addr[2:0] == 3'd0)); // R8
    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> (cnt < max_buf)); // R5
    AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_buf && ev_frame)); // R7
    AST_FRAME_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame |-> (rem == 16'd0)); // R7
    AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= total); // R4
endmodule

// File: rtl/rxr_ring_filler.sv
// Top of the receive descriptor ring filler: frame store feeding the ring
// walker, which owns the memory port. One ring, one frame in flight.
module rxr_ring_filler #(
    parameter int MAX_LEN = 256,
    parameter int AW      = 32,
    localparam int IW = $clog2(MAX_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fin_valid,
    input  logic [7:0]    fin_data,
    input  logic          fin_last,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic [AW-1:0] cfg_ring_base,
    input  logic          cfg_ptr_load,
    input  logic [AW-1:0] cfg_ptr_value,
    input  logic [15:0]   cfg_max_buf,
    input  logic [15:0]   cfg_max_frame,
    input  logic          cfg_cb_en,
    input  logic [4:0]    cfg_cb_pad,
    input  logic          cfg_short_drop,
    input  logic          cfg_rx_en,
    input  logic          cfg_gstop,
    input  logic          ring_restart,
    output logic          ev_buf,
    output logic          ev_frame,
    output logic          ev_drop,
    output logic          ring_halt,
    output logic          busy,
    output logic [AW-1:0] ring_ptr
);
    logic          go, rel;
    logic [15:0]   flen;
    logic [IW-1:0] rd_idx;
    logic [7:0]    rd_byte;

    rxr_frame_store #(.MAX_LEN(MAX_LEN)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (fin_valid),
        .in_data    (fin_data),
        .in_last    (fin_last),
        .rx_en      (cfg_rx_en),
        .gstop      (cfg_gstop),
        .short_drop (cfg_short_drop),
        .release_i  (rel),
        .rd_idx     (rd_idx),
        .rd_byte    (rd_byte),
        .frame_go   (go),
        .frame_len  (flen),
        .ev_drop    (ev_drop)
    );

    rxr_ring_walker #(.AW(AW), .IW(IW)) i_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .frame_len (flen),
        .release_o (rel),
        .rd_idx    (rd_idx),
        .rd_byte   (rd_byte),
        .cb_en     (cfg_cb_en),
        .cb_pad    (cfg_cb_pad),
        .max_buf   (cfg_max_buf),
        .max_frm   (cfg_max_frame),
        .ring_base (cfg_ring_base),
        .ptr_load  (cfg_ptr_load),
        .ptr_value (cfg_ptr_value),
        .restart   (ring_restart),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .ev_buf    (ev_buf),
        .ev_frame  (ev_frame),
        .ring_halt (ring_halt),
        .busy      (busy),
        .ring_ptr  (ring_ptr)
    );
endmodule

// File: tb/test_rxr_ring_filler.sv
// Directed bench for the receive ring filler with a word memory model.
module test_rxr_ring_filler;
    localparam int BASE = 32'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fin_valid = 1'b0, fin_last = 1'b0;
    logic [7:0] fin_data = '0;
    logic mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0] mem_be;
    logic [31:0] mem_rdata = '0;
    logic [31:0] cfg_ring_base = BASE;
    logic cfg_ptr_load = 1'b0;
    logic [31:0] cfg_ptr_value = BASE;
    logic [15:0] cfg_max_buf = 16'd128, cfg_max_frame = 16'd1536;
    logic cfg_cb_en = 1'b0, cfg_short_drop = 1'b0, cfg_rx_en = 1'b1, cfg_gstop = 1'b0;
    logic [4:0] cfg_cb_pad = '0;
    logic ring_restart = 1'b0;
    logic ev_buf, ev_frame, ev_drop, ring_halt, busy;
    logic [31:0] ring_ptr;

    int n_chk = 0, n_fail = 0;
    int n_evb = 0, n_evf = 0, n_drop = 0, n_wr = 0;
    logic [31:0] mem [0:1023];

    always #10 clk = ~clk;

    rxr_ring_filler i_rxr_ring_filler (
        .clk(clk), .rst_n(rst_n), .fin_valid(fin_valid), .fin_data(fin_data),
        .fin_last(fin_last), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cfg_ring_base(cfg_ring_base), .cfg_ptr_load(cfg_ptr_load),
        .cfg_ptr_value(cfg_ptr_value), .cfg_max_buf(cfg_max_buf),
        .cfg_max_frame(cfg_max_frame), .cfg_cb_en(cfg_cb_en), .cfg_cb_pad(cfg_cb_pad),
        .cfg_short_drop(cfg_short_drop), .cfg_rx_en(cfg_rx_en), .cfg_gstop(cfg_gstop),
        .ring_restart(ring_restart), .ev_buf(ev_buf), .ev_frame(ev_frame),
        .ev_drop(ev_drop), .ring_halt(ring_halt), .busy(busy), .ring_ptr(ring_ptr)
    );

    // Memory model: one-cycle read latency, byte-lane writes.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                n_wr = n_wr + 1;
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    // Event pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (ev_buf)   n_evb++;
        if (ev_frame) n_evf++;
        if (ev_drop)  n_drop++;
    end

    function automatic int bufa(int i);
        return 32'h400 + i * 32'h100;
    endfunction

    function automatic int mbyte(int a);
        return int'(mem[a >> 2][(a % 4) * 8 +: 8]);
    endfunction

    function automatic int dflags(int i);
        return int'(mem[(BASE + 8 * i) >> 2][31:16]);
    endfunction

    function automatic int dlen(int i);
        return int'(mem[(BASE + 8 * i) >> 2][15:0]);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic set_desc(int i, logic [15:0] fl);
        mem[(BASE + 8 * i) >> 2]     = {fl, 16'h0000};
        mem[(BASE + 8 * i + 4) >> 2] = bufa(i);
    endtask

    task automatic clear_bufs();
        for (int w = 32'h400 >> 2; w < (32'h800 >> 2); w++) mem[w] = 32'hAAAA_AAAA;
    endtask

    task automatic load_ptr(int v);
        @(negedge clk);
        cfg_ptr_value = v;
        cfg_ptr_load  = 1'b1;
        @(negedge clk);
        cfg_ptr_load  = 1'b0;
    endtask

    task automatic send_frame(int len, int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            fin_valid = 1'b1;
            fin_data  = 8'(seed + i);
            fin_last  = (i == len - 1);
        end
        @(negedge clk);
        fin_valid = 1'b0;
        fin_last  = 1'b0;
    endtask

    task automatic wait_done();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk("R9", "halt after reset", int'(ring_halt), 0);
        chk("R8", "pointer after reset", int'(ring_ptr), 0);
        chk("R4", "no memory request after reset", int'(mem_req), 0);
    endtask

    task automatic test_single();
        int wr0, evf0, evb0;
        clear_bufs();
        set_desc(0, 16'h9000); set_desc(1, 16'h9000);
        set_desc(2, 16'h9000); set_desc(3, 16'hB000);
        load_ptr(BASE);
        chk("R8", "pointer load", int'(ring_ptr), BASE);
        wr0 = n_wr; evf0 = n_evf; evb0 = n_evb;
        send_frame(70, 8'h10);
        wait_done();
        chk("R10", "desc0 status", dflags(0), 16'h1C00);
        chk("R5", "desc0 length", dlen(0), 74);
        chk("R4", "first data byte", mbyte(bufa(0)), 8'h10);
        chk("R4", "last data byte", mbyte(bufa(0) + 69), 8'h55);
        chk("R4", "tail byte 0", mbyte(bufa(0) + 70), 0);
        chk("R4", "tail byte 3", mbyte(bufa(0) + 73), 0);
        chk("R4", "no write past tail", mbyte(bufa(0) + 74), 8'hAA);
        chk("R4", "write count", n_wr - wr0, 75);
        chk("R7", "frame event", n_evf - evf0, 1);
        chk("R7", "no buffer event", n_evb - evb0, 0);
        chk("R8", "pointer after frame", int'(ring_ptr), BASE + 8);
        chk("R5", "desc1 untouched", dflags(1), 16'h9000);
    endtask

    task automatic test_split_cb();
        int evf0, evb0;
        clear_bufs();
        set_desc(0, 16'h9000); set_desc(1, 16'h9000);
        set_desc(2, 16'h9000); set_desc(3, 16'hB000);
        cfg_cb_en = 1'b1; cfg_cb_pad = 5'd2; cfg_max_buf = 16'd20;
        evf0 = n_evf; evb0 = n_evb;
        send_frame(40, 8'h30);
        wait_done();
        chk("R5", "desc1 status first", dflags(1), 16'h1800);
        chk("R5", "desc1 length", dlen(1), 20);
        chk("R5", "desc2 status middle", dflags(2), 16'h1000);
        chk("R5", "desc2 length", dlen(2), 20);
        chk("R6", "desc3 status last short", dflags(3), 16'h3408);
        chk("R5", "desc3 length", dlen(3), 14);
        chk("R3", "control block end zero", mbyte(bufa(1) + 9), 0);
        chk("R3", "control block start zero", mbyte(bufa(1)), 0);
        chk("R3", "data after control block", mbyte(bufa(1) + 10), 8'h30);
        chk("R5", "desc2 first byte", mbyte(bufa(2)), 8'h3A);
        chk("R4", "desc3 last data", mbyte(bufa(3) + 9), 8'h57);
        chk("R4", "desc3 tail", mbyte(bufa(3) + 13), 0);
        chk("R4", "desc3 no overrun", mbyte(bufa(3) + 14), 8'hAA);
        chk("R7", "buffer events", n_evb - evb0, 2);
        chk("R7", "frame events", n_evf - evf0, 1);
        chk("R8", "wrap to base", int'(ring_ptr), BASE);
        cfg_cb_en = 1'b0; cfg_cb_pad = '0;
    endtask

    task automatic test_halt_resume();
        int wr0, drop0;
        clear_bufs();
        set_desc(0, 16'h8000); set_desc(1, 16'h8000);
        set_desc(2, 16'h0000); set_desc(3, 16'hA000);
        cfg_max_buf = 16'd32; cfg_max_frame = 16'd100;
        send_frame(100, 8'h50);
        wait_done();
        chk("R9", "halt raised", int'(ring_halt), 1);
        chk("R9", "pointer past busy desc", int'(ring_ptr), BASE + 24);
        chk("R5", "desc0 first", dflags(0), 16'h0800);
        chk("R5", "desc0 length", dlen(0), 32);
        chk("R5", "desc1 plain", dflags(1), 16'h0000);
        chk("R9", "busy desc length untouched", dlen(2), 0);
        wr0 = n_wr; drop0 = n_drop;
        send_frame(20, 8'h01);
        wait_done();
        chk("R1", "drop while held", n_drop - drop0, 1);
        chk("R1", "no write while held", n_wr - wr0, 0);
        chk("R9", "halt kept", int'(ring_halt), 1);
        set_desc(0, 16'h8000);
        @(negedge clk); ring_restart = 1'b1;
        @(negedge clk); ring_restart = 1'b0;
        wait_done();
        chk("R9", "halt cleared", int'(ring_halt), 0);
        chk("R5", "resumed desc no first", dflags(3), 16'h2000);
        chk("R5", "resumed desc length", dlen(3), 32);
        chk("R9", "resumed data", mbyte(bufa(3)), 8'h90);
        chk("R6", "final desc long", dflags(0), 16'h0420);
        chk("R6", "final desc length", dlen(0), 8);
        chk("R9", "final data", mbyte(bufa(0)), 8'hB0);
        chk("R4", "final tail", mbyte(bufa(0) + 4), 0);
        chk("R8", "pointer after resume", int'(ring_ptr), BASE + 8);
        cfg_max_frame = 16'd1536;
    endtask

    task automatic test_refuse();
        int wr0, drop0;
        wr0 = n_wr; drop0 = n_drop;
        cfg_rx_en = 1'b0;
        send_frame(64, 8'h00);
        wait_done();
        chk("R1", "drop when disabled", n_drop - drop0, 1);
        chk("R1", "no write when disabled", n_wr - wr0, 0);
        cfg_rx_en = 1'b1; cfg_gstop = 1'b1;
        send_frame(64, 8'h00);
        wait_done();
        chk("R1", "drop on graceful stop", n_drop - drop0, 2);
        chk("R1", "no write on graceful stop", n_wr - wr0, 0);
        chk("R1", "pointer unchanged", int'(ring_ptr), BASE + 8);
        cfg_gstop = 1'b0;
    endtask

    task automatic test_short_bounds();
        int wr0, drop0;
        clear_bufs();
        set_desc(0, 16'h9000); set_desc(1, 16'h9000);
        set_desc(2, 16'h9000); set_desc(3, 16'hB000);
        load_ptr(BASE);
        cfg_max_buf = 16'd128; cfg_max_frame = 16'd64; cfg_short_drop = 1'b1;
        wr0 = n_wr; drop0 = n_drop;
        send_frame(59, 8'h20);
        wait_done();
        chk("R2", "59 bytes dropped", n_drop - drop0, 1);
        chk("R2", "no write for 59", n_wr - wr0, 0);
        send_frame(60, 8'h20);
        wait_done();
        chk("R2", "60 bytes accepted", dlen(0), 64);
        chk("R6", "size 64 long not short", dflags(0), 16'h1C20);
        cfg_short_drop = 1'b0;
        send_frame(59, 8'h20);
        wait_done();
        chk("R6", "size 63 short not long", dflags(1), 16'h1C08);
        chk("R6", "size 63 length", dlen(1), 63);
        cfg_max_frame = 16'd1536;
    endtask

    task automatic test_no_irq();
        int evf0, evb0;
        set_desc(2, 16'h8000); set_desc(3, 16'hA000);
        cfg_max_buf = 16'd10;
        evf0 = n_evf; evb0 = n_evb;
        send_frame(10, 8'h70);
        wait_done();
        chk("R7", "no buffer event", n_evb - evb0, 0);
        chk("R7", "no frame event", n_evf - evf0, 0);
        chk("R6", "last desc status", dflags(3), 16'h2408);
        chk("R5", "last desc length", dlen(3), 4);
        chk("R8", "wrap to base", int'(ring_ptr), BASE);
    endtask

    initial begin
        for (int w = 0; w < 1024; w++) mem[w] = '0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_single();
        test_split_cb();
        test_halt_resume();
        test_refuse();
        test_short_bounds();
        test_no_irq();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule